// File: doc/BRIEF.md
# Vectored Multi-Source Interrupt Controller

This block gathers twelve peripheral interrupt lines, each assigned a fixed source index, and turns them into a single prioritized request level for a processor. Every source has its own byte-wide control register. The register holds a latched pending flag, an enable bit and a three-bit priority level. A rising edge on a source input sets its pending flag. Software clears the flag by writing one to that bit.

The controller drives the highest level found among sources that are pending, enabled and have a non-zero level. A global enable bit in a general control register gates every request. When the processor raises its acknowledge strobe together with the level it is servicing, the block returns a vector equal to a programmable base plus the index of the winning source at that level. Ties go to the lowest index. If no source matches, a fixed spurious code is returned.

The register file also carries some per-source features:
- The abort source register shows the live state of its switch input.
- The two software sources can be raised by a register write.
- The serial source can be told whether the controller or the peripheral supplies its vector.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset every source control register reads 0x00, the general control register reads 0x00, the vector base register (address 13) reads 0x40 and the request level is 0.
- R2: A rising edge on source input k sets the pending flag (bit 7 of the register at address k) at the next clock edge. An input held high sets it only once.
- R3: Writing a byte with bit 7 set to a source register clears its pending flag. A write with bit 7 clear leaves the flag as it was. Bit 3 (enable) and bits 2:0 (level) always take the written value.
- R4: While bit 4 of the general control register (address 12) is 1, the request level equals the maximum level of all pending, enabled sources. While it is 0, the request level is 0 and acknowledges return the spurious code.
- R5: A source programmed with level 0 never contributes to the request level and is never selected by an acknowledge.
- R6: While the acknowledge strobe is high, the vector output is the base register plus the index of the lowest-index pending, enabled source whose level equals the acknowledge level.
- R7: An acknowledge that matches no source, including one at level 0, returns the vector 0x0F.
- R8: Bit 6 of the abort source register (index 2) reads the current value of source input 2, independently of its pending flag. In every other source register, bit 6 reads 0.
- R9: Writing a byte with bit 6 set to the register of software source 10 or 11 sets its pending flag. The same bit written to any other source register has no effect.
- R10: Bit 4 of the serial source register (index 3) is stored and read back. When the serial source wins an acknowledge while this bit is 0, the external-vector output is 1; in every other case it is 0.
- R11: The vector base register is read/write, and a new base shifts every returned vector by the same amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 12 | Raw interrupt inputs, bit k is source k |
| reg_addr_i | input | 4 | Register address: 0-11 sources, 12 general control, 13 vector base |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| irq_level_o | output | 3 | Request level to the processor, 0 = none |
| iack_i | input | 1 | Acknowledge strobe |
| iack_level_i | input | 3 | Level being acknowledged |
| iack_vec_o | output | 8 | Vector during acknowledge, 0 otherwise |
| iack_ext_o | output | 1 | Peripheral supplies the vector for this acknowledge |

## Verification
The hardest situation to reach is two sources pending at the same time with chosen relations between their levels. That case is needed to separate highest-level selection from lowest-index tie breaking, and to show that a lower level remains reachable through its own acknowledge. The bench sweeps every ordered pair of sources, once at equal levels and once at levels computed from the indices, and compares with a small arithmetic model after each pair. Source inputs held high through a clear, and the global gate closing while sources are pending, are driven explicitly.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int LVL_W      = 3;
  localparam int DATA_W     = 8;
  localparam int B_PEND     = 7;
  localparam int B_AUX      = 6;  // live switch on read, software set on write
  localparam int B_OWNVEC   = 4;
  localparam int B_EN       = 3;
  localparam int B_GEN      = 4;
  localparam logic [DATA_W-1:0] VEC_SPURIOUS = 8'h0F;
  localparam logic [DATA_W-1:0] BASE_RST     = 8'h40;
endpackage

// File: rtl/vic_pend.sv
module vic_pend #(
  parameter int N = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] src_q;
  logic [N-1:0] rise;

  assign rise = src_i & ~src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_o <= '0;
    end else begin
      src_q  <= src_i;
      // a new edge or software set wins over a same-cycle clear
      pend_o <= (pend_o & ~clr_i) | rise | set_i;
    end
  end

  p_rise_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((pend_o & $past(rise)) == $past(rise)));

  p_w1c_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~rise & ~set_i) != '0) |=> ((pend_o & $past(clr_i & ~rise & ~set_i)) == '0));

  p_soft_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
  parameter int N = 12
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [N-1:0]                    elig_i,
  input  logic [N-1:0][vic_pkg::LVL_W-1:0] lvl_i,
  output logic [vic_pkg::LVL_W-1:0]       level_o
);
  import vic_pkg::*;

  always_comb begin
    level_o = '0;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && lvl_i[i] > level_o) level_o = lvl_i[i];
    end
  end

  p_level_needs_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o != '0) |-> (elig_i != '0));
endmodule

// File: rtl/vic_vec.sv
module vic_vec #(
  parameter int N          = 12,
  parameter int SRC_SERIAL = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N-1:0]                     elig_i,
  input  logic [N-1:0][vic_pkg::LVL_W-1:0] lvl_i,
  input  logic [vic_pkg::LVL_W-1:0]        ack_lvl_i,
  input  logic [vic_pkg::DATA_W-1:0]       base_i,
  input  logic                             own_vec_i,
  output logic                             hit_o,
  output logic                             ext_o,
  output logic [vic_pkg::DATA_W-1:0]       vec_o
);
  import vic_pkg::*;
  localparam int IDX_W = $clog2(N);

  logic [IDX_W-1:0] win;

  always_comb begin
    hit_o = 1'b0;
    win   = '0;
    for (int i = 0; i < N; i++) begin
      if (!hit_o && elig_i[i] && lvl_i[i] == ack_lvl_i) begin
        hit_o = 1'b1;
        win   = IDX_W'(i);
      end
    end
  end

  assign vec_o = hit_o ? base_i + DATA_W'(win) : VEC_SPURIOUS;
  assign ext_o = hit_o && (win == IDX_W'(SRC_SERIAL)) && !own_vec_i;

  p_lvl0_spurious_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_lvl_i == '0) |-> !hit_o);

  p_vec_in_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (DATA_W'(vec_o - base_i) < DATA_W'(N)));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NUM_SRC    = 12,
  parameter int SRC_ABORT  = 2,
  parameter int SRC_SERIAL = 3,
  parameter int SRC_SOFT_A = 10,
  parameter int SRC_SOFT_B = 11,
  parameter int ADDR_W     = $clog2(NUM_SRC + 2)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        src_i,
  input  logic [ADDR_W-1:0]         reg_addr_i,
  input  logic                      reg_wr_i,
  input  logic [7:0]                reg_wdata_i,
  output logic [7:0]                reg_rdata_o,
  output logic [vic_pkg::LVL_W-1:0] irq_level_o,
  input  logic                      iack_i,
  input  logic [vic_pkg::LVL_W-1:0] iack_level_i,
  output logic [7:0]                iack_vec_o,
  output logic                      iack_ext_o
);
  import vic_pkg::*;
  localparam int GCTL_ADDR = NUM_SRC;
  localparam int BASE_ADDR = NUM_SRC + 1;

  logic [NUM_SRC-1:0]            en_q;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
  logic                          own_vec_q;
  logic [DATA_W-1:0]             gctl_q;
  logic [DATA_W-1:0]             base_q;
  logic [NUM_SRC-1:0]            pend;
  logic [NUM_SRC-1:0]            clr;
  logic [NUM_SRC-1:0]            set;
  logic [NUM_SRC-1:0]            sel;
  logic [NUM_SRC-1:0]            elig;
  logic                          gen_en;
  logic                          hit;
  logic                          ext;
  logic [DATA_W-1:0]             vec;

  assign gen_en = gctl_q[B_GEN];

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    assign sel[k]  = reg_wr_i && (reg_addr_i == ADDR_W'(k));
    assign clr[k]  = sel[k] && reg_wdata_i[B_PEND];
    if (k == SRC_SOFT_A || k == SRC_SOFT_B) begin : g_soft
      assign set[k] = sel[k] && reg_wdata_i[B_AUX];
    end else begin : g_hw
      assign set[k] = 1'b0;
    end
    assign elig[k] = pend[k] && en_q[k] && (lvl_q[k] != '0) && gen_en;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[k]  <= 1'b0;
        lvl_q[k] <= '0;
      end else if (sel[k]) begin
        en_q[k]  <= reg_wdata_i[B_EN];
        lvl_q[k] <= reg_wdata_i[LVL_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_vec_q <= 1'b0;
      gctl_q    <= '0;
      base_q    <= BASE_RST;
    end else if (reg_wr_i) begin
      if (reg_addr_i == ADDR_W'(SRC_SERIAL)) own_vec_q <= reg_wdata_i[B_OWNVEC];
      if (reg_addr_i == ADDR_W'(GCTL_ADDR))  gctl_q    <= reg_wdata_i;
      if (reg_addr_i == ADDR_W'(BASE_ADDR))  base_q    <= reg_wdata_i;
    end
  end

  vic_pend #(.N(NUM_SRC)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .clr_i  (clr),
    .set_i  (set),
    .pend_o (pend)
  );

  vic_arb #(.N(NUM_SRC)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .elig_i  (elig),
    .lvl_i   (lvl_q),
    .level_o (irq_level_o)
  );

  vic_vec #(.N(NUM_SRC), .SRC_SERIAL(SRC_SERIAL)) u_vec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .elig_i    (elig),
    .lvl_i     (lvl_q),
    .ack_lvl_i (iack_level_i),
    .base_i    (base_q),
    .own_vec_i (own_vec_q),
    .hit_o     (hit),
    .ext_o     (ext),
    .vec_o     (vec)
  );

  assign iack_vec_o = iack_i ? vec : '0;
  assign iack_ext_o = iack_i && ext;

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reg_addr_i == ADDR_W'(i)) begin
        reg_rdata_o[B_PEND]      = pend[i];
        reg_rdata_o[B_EN]        = en_q[i];
        reg_rdata_o[LVL_W-1:0]   = lvl_q[i];
        if (i == SRC_ABORT)  reg_rdata_o[B_AUX]    = src_i[i];
        if (i == SRC_SERIAL) reg_rdata_o[B_OWNVEC] = own_vec_q;
      end
    end
    if (reg_addr_i == ADDR_W'(GCTL_ADDR)) reg_rdata_o = gctl_q;
    if (reg_addr_i == ADDR_W'(BASE_ADDR)) reg_rdata_o = base_q;
  end

  p_gate_closed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gctl_q[B_GEN] |-> (irq_level_o == '0 && !hit));

  p_ext_only_on_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_ext_o |-> (iack_i && iack_vec_o == base_q + 8'(SRC_SERIAL)));
endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;
  localparam int N = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] irq_level;
  logic       iack = 1'b0;
  logic [2:0] iack_lvl = '0;
  logic [7:0] vec;
  logic       ext;

  int nchk = 0;
  int nerr = 0;

  logic       m_pend [N];
  logic       m_en [N];
  logic [2:0] m_lvl [N];
  logic       m_own;
  logic [7:0] m_gctl;
  logic [7:0] m_base;

  always #10 clk = ~clk;

  vec_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_level_o(irq_level), .iack_i(iack), .iack_level_i(iack_lvl),
    .iack_vec_o(vec), .iack_ext_o(ext)
  );

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic elig(int i);
    return m_pend[i] && m_en[i] && m_lvl[i] != 0 && m_gctl[4];
  endfunction

  function automatic int exp_level();
    int best = 0;
    for (int i = 0; i < N; i++) if (elig(i) && m_lvl[i] > best) best = m_lvl[i];
    return best;
  endfunction

  function automatic int exp_win(int l);
    for (int i = 0; i < N; i++) if (elig(i) && m_lvl[i] == l) return i;
    return -1;
  endfunction

  function automatic int exp_vec(int l);
    int w = exp_win(l);
    return (w < 0) ? 8'h0F : ((m_base + w) & 8'hFF);
  endfunction

  function automatic int exp_rd(int a);
    int v = 0;
    if (a < N) begin
      v = (m_pend[a] << 7) | (m_en[a] << 3) | m_lvl[a];
      if (a == 2) v |= (src[2] << 6);
      if (a == 3) v |= (m_own << 4);
    end else if (a == 12) v = m_gctl;
    else if (a == 13) v = m_base;
    return v;
  endfunction

  task automatic wreg(int a, logic [7:0] d);
    @(negedge clk);
    addr = 4'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    if (a < N) begin
      if (d[7]) m_pend[a] = 1'b0;
      if (d[6] && (a == 10 || a == 11)) m_pend[a] = 1'b1;
      m_en[a] = d[3]; m_lvl[a] = d[2:0];
      if (a == 3) m_own = d[4];
    end else if (a == 12) m_gctl = d;
    else if (a == 13) m_base = d;
  endtask

  task automatic rchk(string req, int a);
    addr = 4'(a);
    #1;
    chk(req, rdata, exp_rd(a));
  endtask

  task automatic pulse(int i);
    @(negedge clk); src[i] = 1'b1;
    @(negedge clk); src[i] = 1'b0;
    m_pend[i] = 1'b1;
  endtask

  task automatic ack(string req, int l, int exp_ext);
    iack = 1'b1; iack_lvl = 3'(l);
    #1;
    chk(req, vec, exp_vec(l));
    if (exp_ext >= 0) chk({req, " ext"}, ext, exp_ext);
    iack = 1'b0;
    #1;
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) wreg(i, 8'h80);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_en[i] = 0; m_lvl[i] = 0; end
    m_own = 0; m_gctl = 0; m_base = 8'h40;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 14; a++) rchk("R1", a);
    chk("R1 level", irq_level, 0);

    wreg(12, 8'h10);
    rchk("R4 gctl", 12);

    // single-source sweep: every source at every level
    for (int i = 0; i < N; i++) begin
      for (int l = 0; l < 8; l++) begin
        wreg(i, 8'h88 | 8'(l));
        pulse(i);
        rchk("R2", i);
        chk("R4/R5 level", irq_level, exp_level());
        ack("R6/R5", l, -1);
        ack("R7", (l + 1) % 8, -1);
        wreg(i, 8'h80);
        rchk("R3", i);
      end
    end

    // pairs: tie on equal level, then index-derived levels
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i == j) continue;
        clear_all();
        wreg(i, 8'h0D); wreg(j, 8'h0D);
        pulse(i); pulse(j);
        ack("R6 tie", 5, -1);
        wreg(i, 8'h08 | 8'((i % 7) + 1));
        wreg(j, 8'h08 | 8'(((j * 3) % 7) + 1));
        chk("R4 pair level", irq_level, exp_level());
        ack("R6 pair hi", m_lvl[i], -1);
        ack("R6 pair lo", m_lvl[j], -1);
      end
    end
    clear_all();

    // R4 global gate
    wreg(5, 8'h0E); pulse(5);
    chk("R4 open", irq_level, 6);
    wreg(12, 8'h00);
    chk("R4 closed", irq_level, 0);
    ack("R4 closed ack", 6, -1);
    wreg(12, 8'h10);
    chk("R4 reopen", irq_level, 6);

    // R3 write with bit7 clear keeps pending
    wreg(5, 8'h0C);
    rchk("R3 keep", 5);
    chk("R3 keep level", irq_level, 4);
    wreg(5, 8'h80);

    // R2 held-high input sets once
    @(negedge clk); src[7] = 1'b1;
    @(negedge clk); m_pend[7] = 1'b1;
    wreg(7, 8'h8B);
    repeat (3) @(negedge clk);
    rchk("R2 held", 7);
    chk("R2 held level", irq_level, 0);
    src[7] = 1'b0;

    // R8 abort live bit
    @(negedge clk); src[2] = 1'b1;
    @(negedge clk); m_pend[2] = 1'b1;
    rchk("R8 live hi", 2);
    src[2] = 1'b0;
    rchk("R8 live lo", 2);
    addr = 4'd6; src[6] = 1'b1; #1;
    chk("R8 other", rdata[6], 0);
    @(negedge clk); src[6] = 1'b0; m_pend[6] = 1'b1;
    clear_all();

    // R9 software set
    wreg(10, 8'h4B);
    rchk("R9 soft10", 10);
    chk("R9 level", irq_level, 3);
    wreg(11, 8'h4C);
    rchk("R9 soft11", 11);
    wreg(5, 8'h4F);
    rchk("R9 ignored", 5);
    chk("R9 ignored level", irq_level, 4);
    clear_all();

    // R10 serial vector ownership
    wreg(3, 8'h0C); pulse(3);
    ack("R10 ext", 4, 1);
    wreg(3, 8'h1C);
    rchk("R10 readback", 3);
    ack("R10 own", 4, 0);
    wreg(9, 8'h0C); pulse(9);
    wreg(3, 8'h0B);
    ack("R10 other", 4, 0);
    clear_all();

    // R11 base shift
    wreg(13, 8'h80);
    rchk("R11 base", 13);
    wreg(8, 8'h0A); pulse(8);
    ack("R11 vec", 2, -1);
    chk("R11 value", vec, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(20 * 200000);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule